// File: doc/BRIEF.md
# QoS Register Save-Restore Engine

This engine preserves the quality-of-service configuration of a power domain's bus ports across a power cycle. A save command starts a walk over the active ports. For each port the engine reads five registers through a register master interface and keeps the values in an internal bank. A restore command performs the same walk and writes the kept values back to the same addresses. A one-cycle done pulse marks the end of either walk. The engine does not interpret the register contents.

Each port has its own base address input. The register offsets within a port are fixed: 0x08, 0x0C, 0x10, 0x14 and 0x18. A runtime port count selects how many ports take part. A count of zero completes at once with no bus traffic. The master has at most one transfer outstanding. Each transfer holds its request until the slave answers with ready.

The controller has three states. `ST_IDLE` waits for a command. `ST_XFER` drives one transfer at a time and steps the walk on each ready. `ST_DONE` raises the done pulse. The transitions are:
- `ST_IDLE` to `ST_XFER` on a command when the count is non-zero.
- `ST_IDLE` to `ST_DONE` on a command when the count is zero.
- `ST_XFER` back to itself on ready when the current transfer is not the last.
- `ST_XFER` to `ST_DONE` on ready of the last transfer.
- `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `qos_ctx_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o` and `bus_req_o` are all low.
- R2: A save performs reads only (`bus_we_o` = 0). Port 0 is handled first and port count-1 last. Within each port the addresses are base+0x08, base+0x0C, base+0x10, base+0x14 and base+0x18, in that order, for 5 × count transfers in total.
- R3: A restore performs writes (`bus_we_o` = 1) in the same address order as a save. Each write carries the value that the last save read from that address. Ports at or above the count are not touched.
- R4: Only one transfer is in flight at a time. While `bus_req_o` is high and `bus_ready_i` is low, the address, direction and write data stay unchanged. A transfer completes on the first rising edge where `bus_ready_i` is sampled high.
- R5: A command given with a port count of zero raises `done_o` in the cycle after the command is sampled, and issues no request.
- R6: `done_o` is high for exactly one cycle, after the last transfer completes. `busy_o` is high from the cycle after an accepted command through the done cycle.
- R7: A save or restore command that arrives while the engine is busy is ignored.
- R8: If save and restore are both asserted in the idle state, the save is performed.
- R9: A port count above NPORTS is treated as NPORTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_i | input | 1 | Start a save walk (sampled while idle) |
| restore_i | input | 1 | Start a restore walk (sampled while idle) |
| port_count_i | input | $clog2(NPORTS+1) | Number of active ports, sampled with the command |
| port_base_i | input | NPORTS*AW | Base address of each port; port p occupies bits [p*AW +: AW] |
| bus_req_o | output | 1 | Transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Transfer address |
| bus_wdata_o | output | DW | Write data |
| bus_ready_i | input | 1 | Slave completes the current transfer |
| bus_rdata_i | input | DW | Read data, valid with ready |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default parameters: four ports, 16-bit addresses and 32-bit data. With these values every port count from zero to four can be swept, along with an over-range count of seven. Each sweep runs against a slave model whose ready latency is fixed at zero or varies from transfer to transfer. This exercises both back-to-back transfers and held requests. Between a save and a restore the bench corrupts the slave registers. This shows that exactly the captured values return, and that ports beyond the count keep their corrupted contents.

// File: rtl/qos_sr_pkg.sv
package qos_sr_pkg;

    localparam int REGS_PER_PORT = 5;
    localparam int FIRST_OFS     = 8;
    localparam int OFS_STRIDE    = 4;
    localparam int RIW           = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } eng_state_e;

    function automatic logic [7:0] reg_offset(input logic [RIW-1:0] idx);
        return 8'(FIRST_OFS + OFS_STRIDE * int'(idx));
    endfunction

endpackage

// File: rtl/qos_sr_walker.sv
module qos_sr_walker
    import qos_sr_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PW     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic [PW-1:0]  last_port,
    output logic [PW-1:0]  port_idx,
    output logic [RIW-1:0] reg_idx,
    output logic           last_o
);

    localparam logic [RIW-1:0] LAST_REG = RIW'(REGS_PER_PORT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_idx <= '0;
            reg_idx  <= '0;
        end else if (clear) begin
            port_idx <= '0;
            reg_idx  <= '0;
        end else if (step) begin
            if (reg_idx == LAST_REG) begin
                reg_idx  <= '0;
                port_idx <= port_idx + 1'b1;
            end else begin
                reg_idx <= reg_idx + 1'b1;
            end
        end
    end

    assign last_o = (reg_idx == LAST_REG) && (port_idx == last_port);

    // R2: the register index never leaves the five-register set
    a_r2_reg_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        reg_idx <= LAST_REG);

    // R2: finishing a port restarts at the lowest offset of the next port
    a_r2_port_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && reg_idx == LAST_REG) |=> (reg_idx == '0));

    // R2: within a port the offsets ascend one at a time
    a_r2_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && reg_idx != LAST_REG) |=> (reg_idx == $past(reg_idx) + 1'b1));

endmodule

// File: rtl/qos_sr_store.sv
module qos_sr_store
    import qos_sr_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PW     = 2,
    parameter int DW     = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [PW-1:0]  port_idx,
    input  logic [RIW-1:0] reg_idx,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data
);

    localparam int NSLOTS = NPORTS * REGS_PER_PORT;

    logic [DW-1:0] slot_q [NSLOTS];
    int            sel;

    always_comb begin
        sel = int'(port_idx) * REGS_PER_PORT + int'(reg_idx);
        if (sel >= NSLOTS) sel = NSLOTS - 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOTS; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[sel] <= wr_data;
        end
    end

    assign rd_data = slot_q[sel];

endmodule

// File: rtl/qos_ctx_engine.sv
module qos_ctx_engine
    import qos_sr_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = 16,
    parameter int DW     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          save_i,
    input  logic                          restore_i,
    input  logic [$clog2(NPORTS+1)-1:0]   port_count_i,
    input  logic [NPORTS*AW-1:0]          port_base_i,
    output logic                          bus_req_o,
    output logic                          bus_we_o,
    output logic [AW-1:0]                 bus_addr_o,
    output logic [DW-1:0]                 bus_wdata_o,
    input  logic                          bus_ready_i,
    input  logic [DW-1:0]                 bus_rdata_i,
    output logic                          busy_o,
    output logic                          done_o
);

    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int CW = $clog2(NPORTS + 1);
    localparam logic [CW-1:0] MAX_CNT = CW'(NPORTS);

    eng_state_e     state_q, state_d;
    logic           restore_mode_q;
    logic [PW-1:0]  last_port_q;

    logic [CW-1:0]  eff_cnt;
    logic           cmd_any;
    logic           accept;
    logic           xfer_done;
    logic           walk_last;
    logic [PW-1:0]  port_idx;
    logic [RIW-1:0] reg_idx;
    logic [DW-1:0]  store_rd;
    logic [AW-1:0]  sel_base;

    // clamp the runtime count to the port capacity
    always_comb begin
        eff_cnt = (port_count_i > MAX_CNT) ? MAX_CNT : port_count_i;
    end

    assign cmd_any   = save_i | restore_i;
    assign accept    = (state_q == ST_IDLE) && cmd_any;
    assign xfer_done = (state_q == ST_XFER) && bus_ready_i;

    qos_sr_walker #(
        .NPORTS (NPORTS),
        .PW     (PW)
    ) walker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_IDLE),
        .step      (xfer_done),
        .last_port (last_port_q),
        .port_idx  (port_idx),
        .reg_idx   (reg_idx),
        .last_o    (walk_last)
    );

    qos_sr_store #(
        .NPORTS (NPORTS),
        .PW     (PW),
        .DW     (DW)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (xfer_done && !restore_mode_q),
        .port_idx (port_idx),
        .reg_idx  (reg_idx),
        .wr_data  (bus_rdata_i),
        .rd_data  (store_rd)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_any) state_d = (eff_cnt == '0) ? ST_DONE : ST_XFER;
            end
            ST_XFER: begin
                if (bus_ready_i && walk_last) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            restore_mode_q <= 1'b0;
            last_port_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                restore_mode_q <= !save_i;
                last_port_q    <= PW'(eff_cnt - 1'b1);
            end
        end
    end

    // outputs
    always_comb begin
        sel_base    = port_base_i[int'(port_idx)*AW +: AW];
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = sel_base + AW'(reg_offset(reg_idx));
        bus_wdata_o = store_rd;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_XFER: begin
                bus_req_o = 1'b1;
                bus_we_o  = restore_mode_q;
            end
            ST_DONE: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // R4: a stalled transfer holds its address, direction and data
    a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ready_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

    // R6: done lasts one cycle and never overlaps a request
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o);

    // R5: zero ports finish immediately without bus traffic
    a_r5_zero_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cmd_any && port_count_i == '0) |=> (done_o && !bus_req_o));

    // R8: save wins when both commands arrive together
    a_r8_save_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && save_i && restore_i && port_count_i != '0) |=> (bus_req_o && !bus_we_o));

    // R7: a command while busy does not restart the walk
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ready_i && cmd_any) |=> (bus_req_o && $stable(bus_addr_o)));

endmodule

// File: tb/qos_ctx_engine_tb_top.sv
module qos_ctx_engine_tb_top;

    localparam int NP = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = $clog2(NP + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              save_i = 1'b0;
    logic              restore_i = 1'b0;
    logic [CW-1:0]     port_count_i = '0;
    logic [NP*AW-1:0]  port_base_i;
    logic              bus_req_o, bus_we_o;
    logic [AW-1:0]     bus_addr_o;
    logic [DW-1:0]     bus_wdata_o;
    logic              bus_ready_i = 1'b0;
    logic [DW-1:0]     bus_rdata_i = '0;
    logic              busy_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qos_ctx_engine #(.NPORTS(NP), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
        .port_count_i(port_count_i), .port_base_i(port_base_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i),
        .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [AW-1:0] base_of(input int p);
        return AW'(((p + 1) << 12) | 16'h0040);
    endfunction

    function automatic logic [DW-1:0] pat(input int p, input int r, input int seed);
        return (32'h9E3779B9 * 32'(seed * 8 + p * 5 + r + 1)) ^ 32'(seed << 20);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // slave model state
    logic [DW-1:0] mem [NP][5];
    logic [AW-1:0] log_addr [64];
    logic          log_we   [64];
    logic [DW-1:0] log_data [64];
    int            log_n = 0;
    int            lat_mode = 0;
    int            xfer_no = 0;
    int            wcnt = 0;
    logic [AW-1:0] held_addr;
    logic          held_we;
    logic [DW-1:0] held_wdata;

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready_i <= 1'b0;
            wcnt = 0;
        end else if (bus_req_o) begin
            int lat;
            if (bus_ready_i) wcnt = 0;
            lat = (lat_mode == 0) ? 0 : (xfer_no % (lat_mode + 1));
            if (wcnt == 0) begin
                held_addr  = bus_addr_o;
                held_we    = bus_we_o;
                held_wdata = bus_wdata_o;
            end else begin
                // R4: stalled request keeps its fields
                chk(bus_addr_o == held_addr && bus_we_o == held_we && bus_wdata_o == held_wdata,
                    "R4 stall hold", DW'(bus_addr_o), DW'(held_addr));
            end
            if (wcnt >= lat) begin
                int p, o;
                p = int'(bus_addr_o >> 12) - 1;
                o = int'(bus_addr_o[11:0]) - 16'h0040 - 8;
                bus_ready_i <= 1'b1;
                bus_rdata_i <= 'x;
                if (p >= 0 && p < NP && o >= 0 && o <= 16 && (o % 4) == 0) begin
                    if (bus_we_o) mem[p][o/4] = bus_wdata_o;
                    else          bus_rdata_i <= mem[p][o/4];
                end
                if (log_n < 64) begin
                    log_addr[log_n] = bus_addr_o;
                    log_we[log_n]   = bus_we_o;
                    log_data[log_n] = bus_we_o ? bus_wdata_o : mem[(p >= 0 && p < NP) ? p : 0][(o >= 0 && o <= 16) ? o/4 : 0];
                end
                log_n++;
                xfer_no++;
                wcnt = 0;
            end else begin
                bus_ready_i <= 1'b0;
                wcnt++;
            end
        end else begin
            bus_ready_i <= 1'b0;
            wcnt = 0;
        end
    end

    // issue a command and wait for done; returns negedges from command drop to done
    task automatic do_cmd(input bit sv, input bit rs, input int cnt, output int ncyc);
        int k;
        @(negedge clk);
        save_i = sv; restore_i = rs; port_count_i = CW'(cnt); log_n = 0;
        @(negedge clk);
        save_i = 0; restore_i = 0;
        k = 1;
        if (cnt > 0) chk(busy_o == 1'b1, "R6 busy after command", DW'(busy_o), 32'd1);
        while (!done_o && k < 2000) begin
            @(negedge clk);
            k++;
        end
        ncyc = k;
        chk(done_o == 1'b1, "R6 done seen", DW'(done_o), 32'd1);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R6 done single pulse", DW'({busy_o, done_o}), 32'd0);
    endtask

    task automatic check_walk(input int nports, input bit is_wr, input int seed, input string req);
        chk(log_n == nports * 5, req, DW'(log_n), DW'(nports * 5));
        for (int i = 0; i < nports * 5 && i < 64; i++) begin
            int p, r;
            p = i / 5; r = i % 5;
            chk(log_addr[i] == base_of(p) + AW'(8 + 4 * r), req, DW'(log_addr[i]), DW'(base_of(p) + AW'(8 + 4 * r)));
            chk(log_we[i] == is_wr, req, DW'(log_we[i]), DW'(is_wr));
            if (is_wr) chk(log_data[i] == pat(p, r, seed), req, log_data[i], pat(p, r, seed));
        end
    endtask

    initial begin
        int nc;
        int seed;
        for (int p = 0; p < NP; p++) port_base_i[p*AW +: AW] = base_of(p);
        for (int p = 0; p < NP; p++) for (int r = 0; r < 5; r++) mem[p][r] = '0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk(busy_o == 1'b0, "R1 busy at reset", DW'(busy_o), 32'd0);
        chk(done_o == 1'b0, "R1 done at reset", DW'(done_o), 32'd0);
        chk(bus_req_o == 1'b0, "R1 req at reset", DW'(bus_req_o), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R3 sweep over counts and latency modes
        seed = 1;
        for (int cnt = 1; cnt <= NP; cnt++) begin
            for (int lm = 0; lm < 3; lm++) begin
                lat_mode = lm;
                for (int p = 0; p < NP; p++) for (int r = 0; r < 5; r++) mem[p][r] = pat(p, r, seed);
                do_cmd(1'b1, 1'b0, cnt, nc);
                check_walk(cnt, 1'b0, seed, "R2 save walk");
                for (int p = 0; p < NP; p++) for (int r = 0; r < 5; r++) mem[p][r] = ~pat(p, r, seed);
                do_cmd(1'b0, 1'b1, cnt, nc);
                check_walk(cnt, 1'b1, seed, "R3 restore walk");
                for (int p = 0; p < NP; p++) for (int r = 0; r < 5; r++) begin
                    if (p < cnt) chk(mem[p][r] == pat(p, r, seed), "R3 restored value", mem[p][r], pat(p, r, seed));
                    else         chk(mem[p][r] == ~pat(p, r, seed), "R3 untouched port", mem[p][r], ~pat(p, r, seed));
                end
                seed++;
            end
        end

        // R5: zero ports
        lat_mode = 0;
        do_cmd(1'b1, 1'b0, 0, nc);
        chk(nc == 1, "R5 save zero done timing", DW'(nc), 32'd1);
        chk(log_n == 0, "R5 save zero no traffic", DW'(log_n), 32'd0);
        do_cmd(1'b0, 1'b1, 0, nc);
        chk(nc == 1, "R5 restore zero done timing", DW'(nc), 32'd1);
        chk(log_n == 0, "R5 restore zero no traffic", DW'(log_n), 32'd0);

        // R8: both commands together perform a save
        for (int p = 0; p < NP; p++) for (int r = 0; r < 5; r++) mem[p][r] = pat(p, r, 90);
        do_cmd(1'b1, 1'b1, 2, nc);
        check_walk(2, 1'b0, 90, "R8 save priority");

        // R9: over-range count clamps to NP
        for (int p = 0; p < NP; p++) for (int r = 0; r < 5; r++) mem[p][r] = pat(p, r, 91);
        do_cmd(1'b1, 1'b0, 7, nc);
        check_walk(NP, 1'b0, 91, "R9 clamp save");

        // R7: commands while busy are ignored
        begin
            int dones;
            lat_mode = 2;
            for (int p = 0; p < NP; p++) for (int r = 0; r < 5; r++) mem[p][r] = pat(p, r, 92);
            @(negedge clk);
            save_i = 1; port_count_i = CW'(NP); log_n = 0;
            @(negedge clk);
            save_i = 0;
            repeat (5) @(negedge clk);
            restore_i = 1;
            @(negedge clk);
            restore_i = 0;
            repeat (3) @(negedge clk);
            save_i = 1; port_count_i = CW'(1);
            @(negedge clk);
            save_i = 0;
            dones = 0;
            for (int k = 0; k < 300; k++) begin
                if (done_o) dones++;
                @(negedge clk);
            end
            chk(dones == 1, "R7 single completion", DW'(dones), 32'd1);
            check_walk(NP, 1'b0, 92, "R7 ignored command");
            // ports hold the saved values: a restore-by-mistake would have written
            chk(mem[0][0] == pat(0, 0, 92), "R7 no write", mem[0][0], pat(0, 0, 92));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule